// File: doc/BRIEF.md
# Peak Overshoot Tracker

This block sits beside a phase-locked loop's feedback divider and keeps the largest phase overshoot seen after a deliberate phase step. The phase error is read as the value of the feedback-divider count at the moment of each reference rising event. That value is held in a sample register and compared with a stored maximum. When the sample is larger, the stored maximum takes the sample's value half a reference period later, at the next reference falling event. Splitting the work this way gives the comparator a full half period to settle before the result is written.

Tracking runs only while the measurement enable is high and the zero-crossing timer has raised its crossing-valid flag. A low-to-high change of the measurement enable starts a new measurement and clears both the maximum and any pending sample. When tracking stops, the maximum keeps its value until the next start, so it can be read out at leisure. All logic runs on the oscillator clock. The reference rise and fall events arrive as single-cycle pulses that are already synchronized to that clock.

Top module: `peak_overshoot_tracker`

## Requirements
- R1: After a synchronous reset the peak output is 0.
- R2: A reference-rise pulse while tracking loads the current divider count into the sample register. Tracking means meas_en=1, cross_valid=1 and no start in that cycle. The captured value becomes visible when a later fall commits it.
- R3: The peak output changes only in the cycle after a reference-fall pulse or a measurement start. A rise pulse alone never moves it.
- R4: On a reference-fall pulse while tracking, if a captured sample exists and is strictly greater than the peak, the peak equals that sample one clock later.
- R5: A captured sample that is equal to or smaller than the peak causes no write at the fall, and the peak is unchanged.
- R6: Between measurement starts the peak never decreases.
- R7: While meas_en=0 or cross_valid=0, rise and fall pulses are ignored and the peak holds its value for readout.
- R8: A 0-to-1 transition of meas_en clears the peak to 0 one clock later and discards any captured sample. Rise and fall pulses in that start cycle are ignored, and a fall that follows before any new rise leaves the peak at 0.
- R9: For rise-captured samples 3, 4, 2, 3, 2, each committed by its own fall, the peak reads 3, 4, 4, 4, 4 after the successive falls, having been 0 before the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_en | input | 1 | Measurement enable; a rising transition starts a new measurement |
| cross_valid | input | 1 | Crossing-valid flag from the zero-crossing timer; gates tracking |
| ref_rise | input | 1 | Single-cycle pulse marking a reference rising event |
| ref_fall | input | 1 | Single-cycle pulse marking a reference falling event |
| div_count | input | CNT_W (6) | Current feedback-divider count |
| peak_out | output | CNT_W (6) | Largest committed sample since the last start |

## Verification
A sample register that holds a wrong value, or a stale armed flag, shows up at peak_out on the clock after the next qualifying fall pulse. Until that fall it is invisible, so the stimulus always pairs rises with later falls and checks the output right after each one. A wrong comparison, whether it writes on an equal or smaller sample or misses a larger one, gives an output that is too high or too low after that fall. A missed clear on start is caught one clock after meas_en rises, and again after a fall that has no new rise before it.

// File: rtl/pot_pkg.sv
package pot_pkg;

    localparam int DEF_CNT_W = 6;

    // per-cycle qualified events derived from the control inputs
    typedef struct packed {
        logic start;    // new measurement begins this cycle
        logic track;    // tracking window open
        logic capture;  // take a sample this cycle
        logic commit;   // write-back opportunity this cycle
    } pot_evt_t;

    function automatic logic gt_u(input logic [31:0] a, input logic [31:0] b);
        return a > b;
    endfunction

endpackage

// File: rtl/pot_ctrl.sv
module pot_ctrl (
    input  logic              clk,
    input  logic              meas_en,
    input  logic              cross_valid,
    input  logic              ref_rise,
    input  logic              ref_fall,
    output pot_pkg::pot_evt_t evt
);
    logic en_q;

    // delayed enable; follows the input even during reset so a start
    // is only seen on a genuine low-to-high transition
    always_ff @(posedge clk) begin
        en_q <= meas_en;
    end

    always_comb begin
        evt.start   = meas_en & ~en_q;
        evt.track   = meas_en & cross_valid & ~evt.start;
        evt.capture = evt.track & ref_rise;
        evt.commit  = evt.track & ref_fall;
    end
endmodule

// File: rtl/pot_sample.sv
module pot_sample #(
    parameter int CNT_W = pot_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  pot_pkg::pot_evt_t evt,
    input  logic [CNT_W-1:0]  div_count,
    output logic [CNT_W-1:0]  smp_q,
    output logic              armed_q
);
    always_ff @(posedge clk) begin
        if (rst || evt.start) begin
            smp_q   <= '0;
            armed_q <= 1'b0;
        end else if (evt.capture) begin
            smp_q   <= div_count;
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pot_commit.sv
module pot_commit #(
    parameter int CNT_W = pot_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  pot_pkg::pot_evt_t evt,
    input  logic [CNT_W-1:0]  smp_q,
    input  logic              armed_q,
    output logic              new_max,
    output logic [CNT_W-1:0]  peak_q
);
    localparam int PADW = 32 - CNT_W;

    // compare has half a reference period to settle before the fall
    assign new_max = armed_q & pot_pkg::gt_u({{PADW{1'b0}}, smp_q},
                                             {{PADW{1'b0}}, peak_q});

    always_ff @(posedge clk) begin
        if (rst || evt.start) begin
            peak_q <= '0;
        end else if (evt.commit && new_max) begin
            peak_q <= smp_q;
        end
    end
endmodule

// File: rtl/peak_overshoot_tracker.sv
module peak_overshoot_tracker #(
    parameter int CNT_W = pot_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_en,
    input  logic             cross_valid,
    input  logic             ref_rise,
    input  logic             ref_fall,
    input  logic [CNT_W-1:0] div_count,
    output logic [CNT_W-1:0] peak_out
);
    pot_pkg::pot_evt_t evt;
    logic [CNT_W-1:0]  smp_q;
    logic              armed_q;
    logic              new_max;

    pot_ctrl u_ctrl (
        .clk         (clk),
        .meas_en     (meas_en),
        .cross_valid (cross_valid),
        .ref_rise    (ref_rise),
        .ref_fall    (ref_fall),
        .evt         (evt)
    );

    pot_sample #(.CNT_W(CNT_W)) u_smp (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .div_count (div_count),
        .smp_q     (smp_q),
        .armed_q   (armed_q)
    );

    pot_commit #(.CNT_W(CNT_W)) u_cmt (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .smp_q   (smp_q),
        .armed_q (armed_q),
        .new_max (new_max),
        .peak_q  (peak_out)
    );
endmodule

// File: rtl/pot_checker.sv
module pot_checker #(
    parameter int CNT_W = pot_pkg::DEF_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             meas_en,
    input logic             cross_valid,
    input logic             ref_rise,
    input logic             ref_fall,
    input logic [CNT_W-1:0] smp_q,
    input logic             armed_q,
    input logic [CNT_W-1:0] peak_out
);
    p_hold_without_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (!ref_fall && !$rose(meas_en)) |=> $stable(peak_out));

    p_commit_larger_r4: assert property (@(posedge clk) disable iff (rst)
        (ref_fall && meas_en && cross_valid && !$rose(meas_en) && armed_q
         && (smp_q > peak_out)) |=> (peak_out == $past(smp_q)));

    p_no_write_le_r5: assert property (@(posedge clk) disable iff (rst)
        (!$rose(meas_en) && (smp_q <= peak_out)) |=> $stable(peak_out));

    p_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
        !$rose(meas_en) |=> (peak_out >= $past(peak_out)));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!(meas_en && cross_valid) && !$rose(meas_en)) |=> $stable(peak_out));

    p_start_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(meas_en) |=> (peak_out == '0 && !armed_q));
endmodule

bind peak_overshoot_tracker pot_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .meas_en     (meas_en),
    .cross_valid (cross_valid),
    .ref_rise    (ref_rise),
    .ref_fall    (ref_fall),
    .smp_q       (smp_q),
    .armed_q     (armed_q),
    .peak_out    (peak_out)
);

// File: tb/sim_peak_overshoot_tracker.sv
`timescale 1ns/1ps
module sim_peak_overshoot_tracker;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         meas_en = 1'b0, cross_valid = 1'b0, ref_rise = 1'b0, ref_fall = 1'b0;
    logic [W-1:0] div_count = '0;
    logic [W-1:0] peak_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench reference state
    bit           m_en_prev = 0;
    bit           m_have = 0;
    logic [W-1:0] m_smp = '0;
    logic [W-1:0] m_peak = '0;

    always #2 clk = ~clk;

    peak_overshoot_tracker #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .meas_en(meas_en), .cross_valid(cross_valid),
        .ref_rise(ref_rise), .ref_fall(ref_fall), .div_count(div_count),
        .peak_out(peak_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // expected behaviour of one clock from the requirements
    function automatic void model_step(input bit r, input bit en, input bit cv,
                                       input bit rise, input bit fall,
                                       input logic [W-1:0] cnt);
        bit starting = en && !m_en_prev;
        bit open_win = en && cv && !starting;
        m_en_prev = en;
        if (r || starting) begin
            m_peak = '0; m_smp = '0; m_have = 0;
        end else if (open_win) begin
            if (fall && m_have && (m_smp > m_peak)) m_peak = m_smp;
            if (rise) begin m_smp = cnt; m_have = 1; end
        end
    endfunction

    task automatic step(input bit en, input bit cv, input bit rise, input bit fall,
                        input logic [W-1:0] cnt);
        meas_en = en; cross_valid = cv; ref_rise = rise; ref_fall = fall; div_count = cnt;
        @(posedge clk);
        model_step(rst, en, cv, rise, fall, cnt);
        @(negedge clk);
    endtask

    task automatic rise_fall(input logic [W-1:0] cnt, input string req);
        step(1, 1, 1, 0, cnt);
        step(1, 1, 0, 0, 6'd0);
        check("R3 rise alone", peak_out, m_peak);
        step(1, 1, 0, 1, 6'd0);
        check(req, peak_out, m_peak);
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] prev;
        process::self().srandom(32'd1234);
        @(negedge clk);
        step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
        check("R1 reset", peak_out, 6'd0);
        rst = 1'b0;

        // R9 directed sequence; start the measurement first (R8)
        step(1, 1, 0, 0, 0);
        check("R8 start", peak_out, 6'd0);
        rise_fall(6'd3, "R9 after 3"); check("R9 v3", peak_out, 6'd3);
        rise_fall(6'd4, "R9 after 4"); check("R9 v4", peak_out, 6'd4);
        rise_fall(6'd2, "R9 after 2"); check("R9 v2", peak_out, 6'd4);
        rise_fall(6'd3, "R9 after 3b"); check("R9 v3b", peak_out, 6'd4);
        rise_fall(6'd2, "R9 after 2b"); check("R9 v2b", peak_out, 6'd4);

        // R2/R4 larger sample; R5 equal sample
        rise_fall(6'd40, "R4 larger"); check("R2 capture", peak_out, 6'd40);
        rise_fall(6'd40, "R5 equal"); check("R5 equal", peak_out, 6'd40);

        // R7 crossing-valid low, then enable low: pulses ignored
        step(1, 0, 1, 0, 6'd60); step(1, 0, 0, 1, 0);
        check("R7 cv low", peak_out, 6'd40);
        step(1, 1, 0, 1, 0);
        check("R7 no capture when cv low", peak_out, 6'd40);
        step(0, 1, 1, 0, 6'd63); step(0, 1, 0, 1, 0);
        check("R7 en low hold", peak_out, 6'd40);

        // R8 restart: clear, pulses in start cycle ignored, fall without rise
        step(1, 1, 1, 1, 6'd50);
        check("R8 clear", peak_out, 6'd0);
        step(1, 1, 0, 1, 0);
        check("R8 stale sample dropped", peak_out, 6'd0);
        rise_fall(6'd63, "R4 max code"); check("R4 max code", peak_out, 6'd63);

        // R6 constrained random with restarts
        prev = peak_out;
        for (int i = 0; i < 3000; i++) begin
            bit en  = ($urandom % 50) != 0;
            bit cv  = ($urandom % 8) != 0;
            bit rs  = ($urandom % 3) == 0;
            bit fl  = ($urandom % 3) == 0;
            bit st  = en && !m_en_prev;
            step(en, cv, rs, fl, 6'($urandom));
            check("R6 random", peak_out, m_peak);
            if (!st && peak_out < prev) check("R6 decreased", peak_out, prev);
            prev = peak_out;
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule